// File: doc/BRIEF.md
# Keyboard Scan Code to ASCII Decoder

This block receives the serial byte stream of a PS/2 keyboard (scan code set 2) on the keyboard's clock and data wires and turns it into ASCII key events for a consumer. The keyboard clock and data are first brought into the system clock domain through synchronizer flops. Each framed byte is checked for a correct start bit, odd parity and stop bit. A watchdog abandons any frame that stalls halfway.

Each accepted code is sorted into one of two kinds. Internal state changes are the release prefix, the extended prefix and the shift, control and alt modifiers. Every other code counts as a real key. A real key press is translated to ASCII, with the current shift state applied, and queued in a small key buffer. The queued entry also carries the control and alt state. A ready output tells the consumer that a key is waiting. The consumer reads the head of the buffer and pulses an acknowledge input to take it.

Top module: `ps2_key_decoder`

## Requirements
- R1: A frame is 11 bits sampled on falling edges of the keyboard clock: a 0 start bit, 8 data bits least significant bit first, an odd parity bit (data plus parity hold an odd number of ones), and a 1 stop bit.
- R2: A frame with wrong parity or a 0 stop bit is discarded and has no effect on the buffer or on the prefix and modifier state.
- R3: If a frame is partly received and no further falling clock edge arrives for TIMEOUT_CYC system clocks, the partial frame is dropped, and the next complete frame decodes correctly.
- R4: Letter codes map to lowercase ASCII, or to uppercase while either shift is held (0x1C gives 0x61, or 0x41 with shift). Digit codes map to digits, or to the symbols on the same US keys with shift (0x16 gives '1' or '!', 0x1E gives '2' or '@'). 0x29 gives a space. Codes with no mapping produce no entry.
- R5: Code 0x5A gives 0x0A (newline) and code 0x66 gives 0x08 (backspace).
- R6: Code 0xF0 marks the next code only as a release. A released key produces no entry, and the code after that is treated as a press again.
- R7: Code 0xE0 marks the next code only as extended. An extended code other than control or alt produces no entry, and the code after that is decoded normally.
- R8: Left shift 0x12 and right shift 0x59 (not extended), control 0x14 and alt 0x11 (with or without 0xE0) are tracked as held or released. They produce no entry. Every entry carries the control state and the alt state at the time of the press.
- R9: key_rdy_o is high while the buffer holds a key, and key_char_o, key_ctrl_o and key_alt_o show the oldest entry. A one-cycle key_ack_i pulse removes that entry, and entries leave in arrival order.
- R10: When the buffer already holds DEPTH keys, a newly translated key is dropped and the stored keys are unchanged.
- R11: After reset the buffer is empty, key_rdy_o is low and all modifiers read as released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kb_dat_i | input | 1 | Keyboard data line, asynchronous |
| key_ack_i | input | 1 | Pulse to remove the oldest buffered key |
| key_rdy_o | output | 1 | A key is waiting in the buffer |
| key_char_o | output | 8 | ASCII code of the oldest buffered key |
| key_ctrl_o | output | 1 | Control was held when the oldest key was pressed |
| key_alt_o | output | 1 | Alt was held when the oldest key was pressed |

## Verification
Directed byte sequences cover separate cases: a bare press, a press with shift held, a release sequence, each prefix followed by a plain key, and a control-held press. Together they show whether the release and extended prefixes really affect only one code, and whether modifiers are latched rather than sampled. Corrupted frames, a stalled half frame followed by a good frame, and a burst of more presses than the buffer can hold show discarding, frame recovery and drop-on-full behaviour. Random presses from a fixed key set, with random shift wrapping and full release sequences, then test the mapping and the shift tracking over longer runs.

// File: rtl/ps2_kbd_pkg.sv
package ps2_kbd_pkg;

    localparam logic [7:0] SC_RELEASE = 8'hF0;
    localparam logic [7:0] SC_EXTEND  = 8'hE0;
    localparam logic [7:0] SC_LSHIFT  = 8'h12;
    localparam logic [7:0] SC_RSHIFT  = 8'h59;
    localparam logic [7:0] SC_CTRL    = 8'h14;
    localparam logic [7:0] SC_ALT     = 8'h11;

    typedef struct packed {
        logic       alt;
        logic       ctrl;
        logic [7:0] ch;
    } key_ent_t;

    // Set 2 make code to ASCII; 0 means "no character".
    function automatic logic [7:0] sc_to_ascii(input logic [7:0] sc, input logic shift);
        logic [7:0] base;
        base = 8'h00;
        case (sc)
            8'h1C: base = "a";  8'h32: base = "b";  8'h21: base = "c";
            8'h23: base = "d";  8'h24: base = "e";  8'h2B: base = "f";
            8'h34: base = "g";  8'h33: base = "h";  8'h43: base = "i";
            8'h3B: base = "j";  8'h42: base = "k";  8'h4B: base = "l";
            8'h3A: base = "m";  8'h31: base = "n";  8'h44: base = "o";
            8'h4D: base = "p";  8'h15: base = "q";  8'h2D: base = "r";
            8'h1B: base = "s";  8'h2C: base = "t";  8'h3C: base = "u";
            8'h2A: base = "v";  8'h1D: base = "w";  8'h22: base = "x";
            8'h35: base = "y";  8'h1A: base = "z";
            8'h16: base = "1";  8'h1E: base = "2";  8'h26: base = "3";
            8'h25: base = "4";  8'h2E: base = "5";  8'h36: base = "6";
            8'h3D: base = "7";  8'h3E: base = "8";  8'h46: base = "9";
            8'h45: base = "0";
            8'h29: base = " ";
            8'h5A: base = 8'h0A;
            8'h66: base = 8'h08;
            default: base = 8'h00;
        endcase
        if (shift) begin
            if (base >= "a" && base <= "z") begin
                base = base - 8'd32;
            end else begin
                case (base)
                    "1": base = "!";  "2": base = "@";  "3": base = "#";
                    "4": base = "$";  "5": base = "%";  "6": base = "^";
                    "7": base = "&";  "8": base = "*";  "9": base = "(";
                    "0": base = ")";
                    default: base = base;
                endcase
            end
        end
        return base;
    endfunction

endpackage

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx #(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk,
    input  logic       kb_dat,
    output logic [7:0] code_o,
    output logic       code_vld_o
);
    localparam int WD_W   = $clog2(TIMEOUT_CYC + 1);
    localparam int NBITS  = 11;
    localparam int CNT_W  = $clog2(NBITS + 1);

    typedef struct packed {
        logic [2:0]       clk_sync;
        logic [1:0]       dat_sync;
        logic [NBITS-1:0] shreg;
        logic [CNT_W-1:0] nbit;
        logic [WD_W-1:0]  wdog;
        logic [7:0]       code;
        logic             vld;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        logic fall;
        logic [NBITS-1:0] nxt;
        st_d = st_q;
        st_d.clk_sync = {st_q.clk_sync[1:0], kb_clk};
        st_d.dat_sync = {st_q.dat_sync[0], kb_dat};
        st_d.vld = 1'b0;
        fall = st_q.clk_sync[2] & ~st_q.clk_sync[1];
        nxt = {st_q.dat_sync[1], st_q.shreg[NBITS-1:1]};
        if (fall) begin
            st_d.shreg = nxt;
            st_d.wdog  = '0;
            if (st_q.nbit == CNT_W'(NBITS - 1)) begin
                st_d.nbit = '0;
                if (!nxt[0] && nxt[10] && (^nxt[9:1])) begin
                    st_d.code = nxt[8:1];
                    st_d.vld  = 1'b1;
                end
            end else begin
                st_d.nbit = st_q.nbit + 1'b1;
            end
        end else if (st_q.nbit != '0) begin
            if (st_q.wdog == WD_W'(TIMEOUT_CYC - 1)) begin
                st_d.nbit = '0;
                st_d.wdog = '0;
            end else begin
                st_d.wdog = st_q.wdog + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.clk_sync <= 3'b111;
            st_q.dat_sync <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o     = st_q.code;
    assign code_vld_o = st_q.vld;
endmodule

// File: rtl/key_xlate.sv
module key_xlate
    import ps2_kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] code_i,
    input  logic       code_vld_i,
    output logic       push_o,
    output key_ent_t   ent_o
);
    typedef struct packed {
        logic     brk;
        logic     ext;
        logic     lsh;
        logic     rsh;
        logic     ctrl;
        logic     alt;
        logic     push;
        key_ent_t ent;
    } xl_st_t;

    xl_st_t st_d, st_q;

    always_comb begin
        logic [7:0] ch;
        st_d = st_q;
        st_d.push = 1'b0;
        ch = 8'h00;
        if (code_vld_i) begin
            if (code_i == SC_RELEASE) begin
                st_d.brk = 1'b1;
            end else if (code_i == SC_EXTEND) begin
                st_d.ext = 1'b1;
            end else begin
                st_d.brk = 1'b0;
                st_d.ext = 1'b0;
                if (code_i == SC_LSHIFT && !st_q.ext) begin
                    st_d.lsh = !st_q.brk;
                end else if (code_i == SC_RSHIFT && !st_q.ext) begin
                    st_d.rsh = !st_q.brk;
                end else if (code_i == SC_CTRL) begin
                    st_d.ctrl = !st_q.brk;
                end else if (code_i == SC_ALT) begin
                    st_d.alt = !st_q.brk;
                end else if (!st_q.brk && !st_q.ext) begin
                    ch = sc_to_ascii(code_i, st_q.lsh | st_q.rsh);
                    if (ch != 8'h00) begin
                        st_d.push     = 1'b1;
                        st_d.ent.ch   = ch;
                        st_d.ent.ctrl = st_q.ctrl;
                        st_d.ent.alt  = st_q.alt;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push_o = st_q.push;
    assign ent_o  = st_q.ent;
endmodule

// File: rtl/key_fifo.sv
module key_fifo
    import ps2_kbd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  key_ent_t                   ent_i,
    input  logic                       pop_i,
    output key_ent_t                   head_o,
    output logic                       rdy_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        key_ent_t [DEPTH-1:0] mem;
        logic [AW-1:0]        wr;
        logic [AW-1:0]        rd;
        logic [CNT_W-1:0]     cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        logic pop_ok, push_ok;
        st_d = st_q;
        pop_ok  = pop_i && (st_q.cnt != '0);
        push_ok = push_i && ((st_q.cnt != CNT_W'(DEPTH)) || pop_ok);
        if (push_ok) begin
            st_d.mem[st_q.wr] = ent_i;
            st_d.wr = nxt_ptr(st_q.wr);
        end
        if (pop_ok) begin
            st_d.rd = nxt_ptr(st_q.rd);
        end
        if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o = st_q.mem[st_q.rd];
    assign rdy_o  = (st_q.cnt != '0);
    assign cnt_o  = st_q.cnt;
endmodule

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder
    import ps2_kbd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000,
    parameter int DEPTH       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_i,
    input  logic       kb_dat_i,
    input  logic       key_ack_i,
    output logic       key_rdy_o,
    output logic [7:0] key_char_o,
    output logic       key_ctrl_o,
    output logic       key_alt_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [7:0]       code_w;
    logic             code_vld_w;
    logic             push_w;
    key_ent_t         ent_w;
    key_ent_t         head_w;
    logic [CNT_W-1:0] cnt_w;

    ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .kb_clk     (kb_clk_i),
        .kb_dat     (kb_dat_i),
        .code_o     (code_w),
        .code_vld_o (code_vld_w)
    );

    key_xlate u_xlate (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_i     (code_w),
        .code_vld_i (code_vld_w),
        .push_o     (push_w),
        .ent_o      (ent_w)
    );

    key_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push_w),
        .ent_i  (ent_w),
        .pop_i  (key_ack_i),
        .head_o (head_w),
        .rdy_o  (key_rdy_o),
        .cnt_o  (cnt_w)
    );

    assign key_char_o = head_w.ch;
    assign key_ctrl_o = head_w.ctrl;
    assign key_alt_o  = head_w.alt;
endmodule

// File: rtl/ps2_key_decoder_chk.sv
module ps2_key_decoder_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [7:0]                 code,
    input logic                       code_vld,
    input logic                       push,
    input logic                       ack,
    input logic                       rdy,
    input logic [$clog2(DEPTH+1)-1:0] cnt
);
    a_r11_reset_empty: assert property (@(posedge clk)
        !rst_n |=> !rdy);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= ($clog2(DEPTH+1))'(DEPTH));

    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !ack) |=> rdy);

    a_r9_last_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && ack && !push && cnt == 1) |=> !rdy);

    a_r1_push_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(code_vld));

    a_r6_release_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && code == 8'hF0) |=> !push);
endmodule

bind ps2_key_decoder ps2_key_decoder_chk #(.DEPTH(DEPTH)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code     (code_w),
    .code_vld (code_vld_w),
    .push     (push_w),
    .ack      (key_ack_i),
    .rdy      (key_rdy_o),
    .cnt      (cnt_w)
);

// File: tb/test_ps2_key_decoder.sv
module test_ps2_key_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT    = 300;
    localparam int DEPTH      = 4;
    localparam int HP         = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kb_clk = 1'b1;
    logic kb_dat = 1'b1;
    logic ack = 1'b0;
    logic rdy;
    logic [7:0] ch;
    logic ctrl, alt;

    int n_chk = 0;
    int n_fail = 0;

    ps2_key_decoder #(.TIMEOUT_CYC(TIMEOUT), .DEPTH(DEPTH)) i_ps2_key_decoder (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
        .key_ack_i(ack), .key_rdy_o(rdy), .key_char_o(ch),
        .key_ctrl_o(ctrl), .key_alt_o(alt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] key_code(input int i);
        case (i)
            0: return 8'h1C; 1: return 8'h32; 2: return 8'h21; 3: return 8'h23;
            4: return 8'h16; 5: return 8'h1E; 6: return 8'h29; default: return 8'h5A;
        endcase
    endfunction

    function automatic logic [7:0] key_exp(input int i, input bit sh);
        case (i)
            0: return sh ? 8'h41 : 8'h61;
            1: return sh ? 8'h42 : 8'h62;
            2: return sh ? 8'h43 : 8'h63;
            3: return sh ? 8'h44 : 8'h64;
            4: return sh ? 8'h21 : 8'h31;
            5: return sh ? 8'h40 : 8'h32;
            6: return 8'h20;
            default: return 8'h0A;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); kb_dat = b;
        repeat (HP) @(negedge clk);
        kb_clk = 1'b0;
        repeat (HP) @(negedge clk);
        kb_clk = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] c, input bit bad_par = 0, input bit bad_stop = 0);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(c[i]);
        send_bit(~(^c) ^ bad_par);
        send_bit(~bad_stop);
        repeat (30) @(negedge clk);
    endtask

    task automatic take(input string req, input logic [7:0] exp_ch, input bit exp_ctrl = 0, input bit exp_alt = 0);
        check(req, {31'd0, rdy}, 32'd1);
        check(req, {24'd0, ch}, {24'd0, exp_ch});
        check(req, {30'd0, ctrl, alt}, {30'd0, exp_ctrl, exp_alt});
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_empty(input string req);
        check(req, {31'd0, rdy}, 32'd0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual hang expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        expect_empty("R11 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_empty("R11 after reset");

        send_byte(8'h1C); take("R1 R4 plain a", 8'h61);
        send_byte(8'h12); expect_empty("R8 shift press no entry");
        send_byte(8'h1C); take("R4 shifted A", 8'h41);
        send_byte(8'hF0); send_byte(8'h12); expect_empty("R8 shift release");
        send_byte(8'h1C); take("R8 shift released", 8'h61);
        send_byte(8'h59); send_byte(8'h1E); take("R4 right shift 2", 8'h40);
        send_byte(8'hF0); send_byte(8'h59);
        send_byte(8'hF0); send_byte(8'h1C); expect_empty("R6 release no entry");
        send_byte(8'h1C); take("R6 one-shot release", 8'h61);
        send_byte(8'h5A); take("R5 newline", 8'h0A);
        send_byte(8'h66); take("R5 backspace", 8'h08);
        send_byte(8'h76); expect_empty("R4 unmapped code");
        send_byte(8'hE0); send_byte(8'h1C); expect_empty("R7 extended no entry");
        send_byte(8'h1C); take("R7 one-shot extended", 8'h61);
        send_byte(8'hE0); send_byte(8'h12); send_byte(8'h1C); take("R7 extended shift ignored", 8'h61);
        send_byte(8'h14); send_byte(8'h32); take("R8 ctrl flag", 8'h62, 1, 0);
        send_byte(8'hF0); send_byte(8'h14);
        send_byte(8'hE0); send_byte(8'h11); send_byte(8'h21); take("R8 alt flag", 8'h63, 0, 1);
        send_byte(8'hE0); send_byte(8'hF0); send_byte(8'h11);
        send_byte(8'h21); take("R8 alt released", 8'h63, 0, 0);

        send_byte(8'h1C, 1, 0); expect_empty("R2 bad parity");
        send_byte(8'h1C, 0, 1); expect_empty("R2 bad stop");
        send_byte(8'hF0, 1, 0); send_byte(8'h1C); take("R2 bad release prefix ignored", 8'h61);

        for (int i = 0; i < 5; i++) send_bit(1'b1);
        repeat (TIMEOUT + 50) @(negedge clk);
        expect_empty("R3 partial frame");
        send_byte(8'h32); take("R3 recovery", 8'h62);

        for (int i = 0; i < DEPTH + 2; i++) send_byte(key_code(i));
        for (int i = 0; i < DEPTH; i++) take("R9 R10 order", key_exp(i, 0));
        expect_empty("R10 extra dropped");

        for (int n = 0; n < 30; n++) begin
            int k = int'($urandom % 8);
            bit sh = bit'($urandom % 2);
            if (sh) send_byte(8'h12);
            send_byte(key_code(k));
            send_byte(8'hF0); send_byte(key_code(k));
            if (sh) begin send_byte(8'hF0); send_byte(8'h12); end
            take("R4 random", key_exp(k, sh));
            expect_empty("R6 random release");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule